// File: doc/BRIEF.md
# Shadowed Fetch-Channel Control Registers

This block is the control register bank of one display fetch channel. Software reaches it through a small request port. Every register occupies four consecutive word addresses. The first replaces the register, the second ORs the written ones into it, the third clears them and the fourth inverts them. The bank holds a system word and two frame words: a frame control word with pitch, rotation and flips, and a frame base address.

The frame words are double buffered. Software writes land in working copies, and the fetch engine sees only the active copies on the output ports. Working copies move to the active copies on a shadow-load event. For the first frame, software raises that event by writing run while the software-select bit is set. Afterwards the select bit is cleared and every frame-start pulse from the timing logic raises it. Run clears itself at frame start unless repeat is on. A soft-reset bit holds the whole bank at its defaults until software drops the bit again.

Top module: `chan_ctrl_regs`

## Requirements
- R1: Address bits [3:2] pick the access kind: 0 replace, 1 set the written ones, 2 clear the written ones, 3 invert the written ones. Bits [ADDR_W-1:4] pick the register: 0 system word, 1 frame control, 2 base address. Writes to any other register index are ignored, and reads from one return 0. A read through any of the four aliases returns the same value.
- R2: A read request places the register value on rsp_rdata one cycle later, and rsp_rdata holds it until the next read. Frame words read back their working copies.
- R3: System word layout: bit 0 run, bit 1 soft reset, bit 2 repeat, bit 3 shadow-load enable, bit 4 software load select. Bits [31:5] read 0.
- R4: Frame control layout: pitch in [31:16], rotate-before-flip in [4], rotation in quarter turns in [3:2], vertical flip in [1], horizontal flip in [0]. All other bits read 0.
- R5: Writes to the frame words change only the working copies. The active outputs stay unchanged until a shadow-load event.
- R6: Any write that leaves the system word with run, shadow-load enable and software select at 1 and soft reset at 0 is a software trigger. One cycle after such a write is accepted, the active outputs carry the working values and shadow_loaded is high for exactly that cycle.
- R7: A frame_start pulse with shadow-load enable at 1, software select at 0 and soft reset at 0 loads the active copies at that edge and raises shadow_loaded in the next cycle. A frame_start while software select is 1 or shadow-load enable is 0 loads nothing.
- R8: A frame_start clears run when repeat is 0 and leaves run at 1 when repeat is 1.
- R9: When a load and a write to a frame word fall in the same cycle, the active copy takes the pre-write working value and the write lands in the working copy. When a system-word write meets frame_start, the write is applied to the value left after the frame-start update of run.
- R10: While soft reset is 1, all other system bits read 0. From the next cycle on, the working and active copies are 0, writes to the frame words are ignored and frame_start loads nothing. Clearing the bit releases the bank.
- R11: After rst_n, every register, every active output, rsp_rdata and shadow_loaded are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W-2 | Word address (byte address bits [ADDR_W-1:2]) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| frame_start | input | 1 | Frame-start pulse from the timing logic |
| run | output | 1 | Run bit of the system word |
| repeat_on | output | 1 | Repeat bit of the system word |
| soft_reset | output | 1 | Soft-reset bit of the system word |
| shadow_loaded | output | 1 | One-cycle pulse after each shadow load |
| act_pitch | output | 16 | Active pitch |
| act_rot | output | 2 | Active rotation in quarter turns |
| act_rot_first | output | 1 | Active rotate-before-flip order |
| act_vflip | output | 1 | Active vertical flip |
| act_hflip | output | 1 | Active horizontal flip |
| act_base | output | 32 | Active frame base address |

## Verification
Two pairs of functions can meet in one cycle. A hardware shadow load can coincide with a software write to the frame control word, and the frame-start clearing of run can coincide with a set-alias write to the system word. The bench drives a write and frame_start in the same cycle. It then checks that the active outputs hold the old working value while a readback shows the new one. It also checks that setting run survives a frame-start clear, while setting only repeat in that cycle leaves run at 0.

// File: rtl/chan_regs_pkg.sv
`timescale 1ns/1ps
package chan_regs_pkg;

  localparam int DATA_W  = 32;
  localparam int PITCH_W = 16;
  localparam int SYS_W   = 5;

  // system word bit positions
  localparam int BIT_RUN   = 0;
  localparam int BIT_SRST  = 1;
  localparam int BIT_RPT   = 2;
  localparam int BIT_SLD   = 3;
  localparam int BIT_SWSEL = 4;

  // register indices
  localparam int IDX_SYS    = 0;
  localparam int IDX_FRAME  = 1;
  localparam int NUM_SHADOW = 2;

  localparam logic [DATA_W-1:0] FRAME_MASK = 32'hFFFF_001F;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  function automatic logic [DATA_W-1:0] shadow_mask(int slot);
    return (slot == 0) ? FRAME_MASK : {DATA_W{1'b1}};
  endfunction

endpackage

// File: rtl/chan_regs_alias.sv
`timescale 1ns/1ps
module chan_regs_alias
  import chan_regs_pkg::*;
#(
  parameter int W = 32
) (
  input  alias_op_e      op,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   wdata,
  input  logic [W-1:0]   mask,
  output logic [W-1:0]   nxt
);

  logic [W-1:0] raw;

  always_comb begin
    unique case (op)
      OP_WRITE: raw = wdata;
      OP_SET:   raw = cur | wdata;
      OP_CLR:   raw = cur & ~wdata;
      default:  raw = cur ^ wdata;
    endcase
    nxt = raw & mask;
  end

endmodule

// File: rtl/chan_regs_shadow.sv
`timescale 1ns/1ps
module chan_regs_shadow
  import chan_regs_pkg::*;
#(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = {W{1'b1}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  alias_op_e     op,
  input  logic [W-1:0]  wdata,
  input  logic          hold_clr,
  input  logic          load,
  output logic [W-1:0]  work_q,
  output logic [W-1:0]  act_q
);

  logic [W-1:0] alu_nxt;
  logic [W-1:0] work_d;
  logic [W-1:0] act_d;

  chan_regs_alias #(.W(W)) u_alu (
    .op    (op),
    .cur   (work_q),
    .wdata (wdata),
    .mask  (MASK),
    .nxt   (alu_nxt)
  );

  always_comb begin
    work_d = work_q;
    act_d  = act_q;
    if (hold_clr) begin
      work_d = '0;
      act_d  = '0;
    end else begin
      if (load)  act_d  = work_q;
      if (wr_en) work_d = alu_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      act_q  <= '0;
    end else begin
      work_q <= work_d;
      act_q  <= act_d;
    end
  end

  // R5: active copy moves only on a load or a soft-reset hold
  a_r5_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !hold_clr) |=> $stable(act_q));

  // R9: a load takes the working value seen before any same-cycle write
  a_r9_load_old_value: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !hold_clr) |=> (act_q == $past(work_q)));

endmodule

// File: rtl/chan_regs_sysctl.sv
`timescale 1ns/1ps
module chan_regs_sysctl
  import chan_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  alias_op_e        op,
  input  logic [SYS_W-1:0] wdata,
  input  logic             frame_start,
  output logic [SYS_W-1:0] sys_q,
  output logic             sw_trig_q,
  output logic             hw_load
);

  localparam logic [SYS_W-1:0] SYS_MASK = {SYS_W{1'b1}};
  localparam logic [SYS_W-1:0] SRST_ONLY = SYS_W'(1) << BIT_SRST;

  logic [SYS_W-1:0] after_fs;
  logic [SYS_W-1:0] alu_nxt;
  logic [SYS_W-1:0] sys_d;
  logic             trig_d;

  always_comb begin
    after_fs = sys_q;
    if (frame_start && !sys_q[BIT_SRST])
      after_fs[BIT_RUN] = sys_q[BIT_RUN] & sys_q[BIT_RPT];
  end

  chan_regs_alias #(.W(SYS_W)) u_alu (
    .op    (op),
    .cur   (after_fs),
    .wdata (wdata),
    .mask  (SYS_MASK),
    .nxt   (alu_nxt)
  );

  always_comb begin
    sys_d = wr_en ? alu_nxt : after_fs;
    if (sys_d[BIT_SRST]) sys_d = SRST_ONLY;
    trig_d = wr_en && sys_d[BIT_RUN] && sys_d[BIT_SLD] &&
             sys_d[BIT_SWSEL] && !sys_d[BIT_SRST];
    hw_load = frame_start && sys_q[BIT_SLD] && !sys_q[BIT_SWSEL] &&
              !sys_q[BIT_SRST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q     <= '0;
      sw_trig_q <= 1'b0;
    end else begin
      sys_q     <= sys_d;
      sw_trig_q <= trig_d;
    end
  end

  // R8: without repeat, a frame start drops run unless software rewrites it
  a_r8_run_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !wr_en && !sys_q[BIT_RPT]) |=> !sys_q[BIT_RUN]);

  // R10: soft reset stays until software writes the system word
  a_r10_srst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_q[BIT_SRST] && !wr_en) |=> sys_q[BIT_SRST]);

  // R10: nothing runs while soft reset is held
  a_r10_srst_no_run: assert property (@(posedge clk) disable iff (!rst_n)
    sys_q[BIT_SRST] |-> (!sys_q[BIT_RUN] && !sw_trig_q));

endmodule

// File: rtl/chan_ctrl_regs.sv
`timescale 1ns/1ps
module chan_ctrl_regs
  import chan_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:2]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic                 frame_start,
  output logic                 run,
  output logic                 repeat_on,
  output logic                 soft_reset,
  output logic                 shadow_loaded,
  output logic [PITCH_W-1:0]   act_pitch,
  output logic [1:0]           act_rot,
  output logic                 act_rot_first,
  output logic                 act_vflip,
  output logic                 act_hflip,
  output logic [DATA_W-1:0]    act_base
);

  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0]  idx;
  alias_op_e         op;
  logic              wr_req;
  logic              rd_req;
  logic [SYS_W-1:0]  sys_q;
  logic              sw_trig_q;
  logic              hw_load;
  logic              load;
  logic              srst;
  logic [DATA_W-1:0] work_q [NUM_SHADOW];
  logic [DATA_W-1:0] act_q  [NUM_SHADOW];
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_d;
  logic              loaded_d;

  assign idx    = req_addr[ADDR_W-1:4];
  assign op     = alias_op_e'(req_addr[3:2]);
  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;
  assign srst   = sys_q[BIT_SRST];
  assign load   = (sw_trig_q || hw_load) && !srst;

  chan_regs_sysctl u_sys (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_req && (int'(idx) == IDX_SYS)),
    .op          (op),
    .wdata       (req_wdata[SYS_W-1:0]),
    .frame_start (frame_start),
    .sys_q       (sys_q),
    .sw_trig_q   (sw_trig_q),
    .hw_load     (hw_load)
  );

  for (genvar g = 0; g < NUM_SHADOW; g++) begin : g_shadow
    localparam logic [DATA_W-1:0] SLOT_MASK = shadow_mask(g);
    chan_regs_shadow #(.W(DATA_W), .MASK(SLOT_MASK)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_req && !srst && (int'(idx) == IDX_FRAME + g)),
      .op       (op),
      .wdata    (req_wdata),
      .hold_clr (srst),
      .load     (load),
      .work_q   (work_q[g]),
      .act_q    (act_q[g])
    );
  end

  always_comb begin
    rd_val = '0;
    if (int'(idx) == IDX_SYS) rd_val = {{(DATA_W-SYS_W){1'b0}}, sys_q};
    for (int s = 0; s < NUM_SHADOW; s++) begin
      if (int'(idx) == IDX_FRAME + s) rd_val = work_q[s];
    end
    rdata_d  = rd_req ? rd_val : rsp_rdata;
    loaded_d = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata     <= '0;
      shadow_loaded <= 1'b0;
    end else begin
      rsp_rdata     <= rdata_d;
      shadow_loaded <= loaded_d;
    end
  end

  assign run           = sys_q[BIT_RUN];
  assign repeat_on     = sys_q[BIT_RPT];
  assign soft_reset    = srst;
  assign act_pitch     = act_q[0][31:16];
  assign act_rot_first = act_q[0][4];
  assign act_rot       = act_q[0][3:2];
  assign act_vflip     = act_q[0][1];
  assign act_hflip     = act_q[0][0];
  assign act_base      = act_q[1];

  // R6: a software trigger is followed by the loaded pulse
  a_r6_sw_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig_q |=> shadow_loaded);

  // R7: frame start under software select never loads
  a_r7_no_hw_load_swsel: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && sys_q[BIT_SWSEL] && !sw_trig_q) |=> !shadow_loaded);

  // R2: system word read data appears one cycle after the request
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (int'(idx) == IDX_SYS)) |=>
      (rsp_rdata == {{(DATA_W-SYS_W){1'b0}}, $past(sys_q)}));

  // R10: soft reset suppresses the loaded pulse
  a_r10_no_pulse_in_srst: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && !sw_trig_q) |=> !shadow_loaded);

endmodule

// File: tb/sim_chan_ctrl_regs.sv
`timescale 1ns/1ps
module sim_chan_ctrl_regs;

  localparam int ADDR_W = 8;
  localparam logic [31:0] FMASK = 32'hFFFF_001F;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [ADDR_W-1:2] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic        frame_start;
  logic        run, repeat_on, soft_reset, shadow_loaded;
  logic [15:0] act_pitch;
  logic [1:0]  act_rot;
  logic        act_rot_first, act_vflip, act_hflip;
  logic [31:0] act_base;

  int n_run;
  int n_fail;
  bit done;

  chan_ctrl_regs #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .frame_start(frame_start), .run(run), .repeat_on(repeat_on),
    .soft_reset(soft_reset), .shadow_loaded(shadow_loaded),
    .act_pitch(act_pitch), .act_rot(act_rot), .act_rot_first(act_rot_first),
    .act_vflip(act_vflip), .act_hflip(act_hflip), .act_base(act_base)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] apply(logic [31:0] c, int op, logic [31:0] d,
                                        logic [31:0] m);
    logic [31:0] r;
    case (op)
      0: r = d;
      1: r = c | d;
      2: r = c & ~d;
      default: r = c ^ d;
    endcase
    return r & m;
  endfunction

  function automatic logic [31:0] act_frame();
    return {act_pitch, 11'b0, act_rot_first, act_rot, act_vflip, act_hflip};
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(int idx, int op, logic [31:0] d, bit we, bit fs);
    @(negedge clk);
    req_valid   = 1'b1;
    req_write   = we;
    req_addr    = {idx[3:0], op[1:0]};
    req_wdata   = d;
    frame_start = fs;
    @(negedge clk);
    req_valid   = 1'b0;
    req_write   = 1'b0;
    frame_start = 1'b0;
  endtask

  task automatic wr(int idx, int op, logic [31:0] d);
    drive(idx, op, d, 1'b1, 1'b0);
  endtask

  task automatic rd(int idx, int op, logic [31:0] exp, string tag);
    drive(idx, op, 32'h0, 1'b0, 1'b0);
    chk(rsp_rdata, exp, tag);
  endtask

  task automatic pulse_fs();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] mf, mb, af, ab;
    logic [31:0] pats [6];
    n_run = 0; n_fail = 0; done = 0;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h1234_0015; pats[2] = 32'hA5A5_5A5A;
    pats[3] = 32'h0F0F_000C; pats[4] = 32'h8001_0003; pats[5] = 32'h0000_0010;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; frame_start = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();

    // R11 reset state
    chk({28'b0, run, repeat_on, soft_reset, shadow_loaded}, 32'h0, "R11 outputs");
    chk(act_frame(), 32'h0, "R11 active frame");
    chk(act_base, 32'h0, "R11 active base");
    chk(rsp_rdata, 32'h0, "R11 rdata");
    rd(0, 0, 32'h0, "R11 sys");
    rd(1, 0, 32'h0, "R11 frame");
    rd(2, 0, 32'h0, "R11 base");

    // R1 R4 R5 alias sweep on both frame words, read back through every alias
    mf = 0; mb = 0;
    for (int p = 0; p < 6; p++) begin
      for (int op = 0; op < 4; op++) begin
        mf = apply(mf, op, pats[p], FMASK);
        wr(1, op, pats[p]);
        rd(1, (op + p) % 4, mf, "R1 R4 frame alias");
        mb = apply(mb, op, pats[5-p], 32'hFFFF_FFFF);
        wr(2, op, pats[5-p]);
        rd(2, op, mb, "R1 base alias");
      end
    end
    chk(act_frame(), 32'h0, "R5 active frame untouched");
    chk(act_base, 32'h0, "R5 active base untouched");

    // R1 unmapped indices
    for (int i = 3; i < 16; i++) begin
      wr(i, 0, 32'hDEAD_BEEF);
      rd(i, 0, 32'h0, "R1 unmapped read");
    end
    rd(1, 0, mf, "R1 unmapped write ignored");
    rd(0, 0, 32'h0, "R1 sys unaffected");

    // R3 layout: high bits dropped, repeat held
    wr(0, 0, 32'hFFFF_FFE4);
    rd(0, 3, 32'h4, "R3 sys width");
    chk({31'b0, repeat_on}, 32'h1, "R3 repeat bit");
    wr(0, 0, 32'h0);

    // R2 read data holds between reads
    rd(1, 0, mf, "R2 read");
    tick(); tick();
    chk(rsp_rdata, mf, "R2 hold");

    // R6 software load
    af = mf; ab = mb;
    wr(0, 0, 32'h19);
    chk({31'b0, shadow_loaded}, 32'h0, "R6 no pulse yet");
    chk(act_frame(), 32'h0, "R6 not loaded yet");
    tick();
    chk({31'b0, shadow_loaded}, 32'h1, "R6 pulse");
    chk(act_frame(), af, "R6 frame loaded");
    chk(act_base, ab, "R6 base loaded");
    tick();
    chk({31'b0, shadow_loaded}, 32'h0, "R6 one cycle");
    chk({31'b0, run}, 32'h1, "R6 run set");

    // R8 run self clear, R7 no load under software select
    wr(1, 0, 32'h0040_0001); mf = 32'h0040_0001;
    pulse_fs();
    chk({31'b0, shadow_loaded}, 32'h0, "R7 swsel blocks load");
    chk({31'b0, run}, 32'h0, "R8 run cleared");
    chk(act_frame(), af, "R7 active kept");
    wr(0, 1, 32'h4);
    wr(0, 1, 32'h1);
    tick(); tick();
    af = mf;
    chk(act_frame(), af, "R6 retrigger load");
    pulse_fs();
    chk({31'b0, run}, 32'h1, "R8 repeat keeps run");
    rd(0, 0, 32'h1D, "R8 sys value");

    // R7 hardware load
    wr(0, 2, 32'h10);
    wr(1, 0, 32'h0200_0016); mf = 32'h0200_0016;
    chk(act_frame(), af, "R5 working only");
    pulse_fs();
    chk({31'b0, shadow_loaded}, 32'h1, "R7 hw pulse");
    chk(act_frame(), mf, "R7 hw load");
    af = mf;
    tick();
    chk({31'b0, shadow_loaded}, 32'h0, "R7 pulse one cycle");
    wr(0, 2, 32'h8);
    wr(1, 0, 32'h0300_0008); mf = 32'h0300_0008;
    pulse_fs();
    chk({31'b0, shadow_loaded}, 32'h0, "R7 disabled no pulse");
    chk(act_frame(), af, "R7 disabled no load");
    wr(0, 1, 32'h8);

    // R9 write and load in the same cycle
    drive(1, 0, 32'h0400_000F, 1'b1, 1'b1);
    chk(act_frame(), mf, "R9 load takes old working");
    rd(1, 0, 32'h0400_000F, "R9 write lands in working");
    pulse_fs();
    chk(act_frame(), 32'h0400_000F, "R9 next load");
    wr(0, 2, 32'h4);
    drive(0, 1, 32'h1, 1'b1, 1'b1);
    chk({31'b0, run}, 32'h1, "R9 set run beats clear");
    drive(0, 1, 32'h4, 1'b1, 1'b1);
    chk({31'b0, run}, 32'h0, "R9 set repeat after clear");
    rd(0, 0, 32'h0C, "R9 sys value");

    // R10 soft reset
    wr(0, 1, 32'h2);
    chk({31'b0, soft_reset}, 32'h1, "R10 srst out");
    rd(0, 0, 32'h2, "R10 other bits cleared");
    chk(act_frame(), 32'h0, "R10 active frame cleared");
    chk(act_base, 32'h0, "R10 active base cleared");
    rd(2, 0, 32'h0, "R10 working cleared");
    wr(1, 0, 32'h1111_0001);
    rd(1, 0, 32'h0, "R10 write ignored");
    wr(0, 1, 32'h8);
    rd(0, 0, 32'h2, "R10 set ignored");
    pulse_fs();
    chk({31'b0, shadow_loaded}, 32'h0, "R10 no load");
    wr(0, 2, 32'h2);
    rd(0, 0, 32'h0, "R10 released");
    wr(1, 0, 32'h1111_0001);
    rd(1, 0, 32'h1111_0001, "R10 writes resume");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule